// File: doc/BRIEF.md
# Capture-to-Host DMA Byte FIFO

This block carries image bytes captured on one clock into a host processor's external DMA engine, which runs on a separate clock supplied by the host. On the capture side, a byte is accepted whenever the capture logic marks it valid, the host has started acquisition, and the queue has space. Bytes offered outside those conditions are discarded.

On the host side, an active-low request line stays low for as long as data is waiting. The host serves one byte per DMA service in single-service fashion. Each service is signalled by a low-going acknowledge. The byte at the head of the queue is on the read data bus while the acknowledge is low. The falling edge of the acknowledge retires that byte.

The storage is a register array whose depth is a power of two. Binary read and write pointers each carry one extra wrap bit. Each pointer is converted to Gray code and passed to the opposite clock through a two-flop synchronizer. Full is then decided in the write domain and empty in the read domain. An acknowledge that arrives while the queue is empty is ignored, and it sets a sticky underflow flag that only reset clears.

Top module: `capture_dma_fifo`

## Requirements
- R1: `wrReady` is 1 exactly when `startAcq` is 1 and the queue is not full. A queue holding DEPTH bytes drives `wrReady` to 0 from the write-clock edge that stored the last byte.
- R2: A byte is stored only on a rising `wrClk` edge where `capValid` and `wrReady` are both 1. A byte offered while `startAcq` is 0 never appears at the read side.
- R3: When more than DEPTH bytes are offered with no reads, only the first DEPTH are kept. They are read out in arrival order, and the queue never holds more than DEPTH bytes.
- R4: `dmaReqN` is 1 while the queue is empty. It goes to 0 within four `rdClk` cycles after a byte is stored. It stays at 0 until the last stored byte has been retired.
- R5: `rdData` shows the oldest unread byte. A falling edge of `dmaAckN` (sampled 1 then 0 on consecutive `rdClk` edges) retires exactly one byte, and bytes leave in the order they arrived.
- R6: An acknowledge held low for several `rdClk` cycles retires only one byte.
- R7: A falling edge of `dmaAckN` while the queue is empty changes no pointer and sets `underflow` to 1. `underflow` then stays at 1 until reset, and later traffic is delivered correctly.
- R8: After reset (`rstN` low, asynchronous, common to both clocks) the queue is empty. In that state `dmaReqN` is 1, `underflow` is 0, and `wrReady` follows `startAcq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Capture-side clock |
| rdClk | input | 1 | Host-side clock, independent of wrClk |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| startAcq | input | 1 | Host acquisition enable; gates writes |
| capValid | input | 1 | Capture byte valid strobe (wrClk domain) |
| capData | input | DW | Capture byte |
| wrReady | output | 1 | Write request: acquisition on and room available |
| rdData | output | DW | Head byte presented to the host bus |
| dmaReqN | output | 1 | Active-low DMA request, low while data is waiting |
| dmaAckN | input | 1 | Active-low DMA acknowledge (rdClk domain) |
| underflow | output | 1 | Sticky flag: acknowledge seen while empty |

## Verification
The hardest condition to reach from the ports is the full boundary. Both clocks keep running, and the read-side pointer arrives in the write domain late, so the full flag must be shown to engage at exactly DEPTH bytes and to drop extra bytes. The stimulus keeps the acknowledge idle and pushes DEPTH+3 bytes back to back. It checks that `wrReady` has fallen, then drains the queue and confirms that only the first DEPTH bytes come out, in order. The empty-side acknowledge and the long acknowledge pulse are reached in the same way: the queue is first left empty, or holding exactly two bytes, before the acknowledge is driven.

// File: rtl/cdc_bridge_pkg.sv
package cdc_bridge_pkg;
  // Control-to-datapath strobes, one per clock domain.
  typedef struct packed {
    logic push;  // wrClk domain: store capData, advance write pointer
    logic pop;   // rdClk domain: advance read pointer
  } fifoStrobe_t;
endpackage

// File: rtl/ptr_sync.sv
module ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/fifo_store.sv
module fifo_store
  import cdc_bridge_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  fifoStrobe_t   strobe,
  input  logic [DW-1:0] capData,
  output logic [DW-1:0] rdData,
  output logic [PW-1:0] wrPtrBin,
  output logic [PW-1:0] rdPtrBin
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)            wrPtrBin <= '0;
    else if (strobe.push) wrPtrBin <= wrPtrBin + 1'b1;
  end

  always_ff @(posedge wrClk) begin
    if (strobe.push) mem[wrPtrBin[AW-1:0]] <= capData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)           rdPtrBin <= '0;
    else if (strobe.pop) rdPtrBin <= rdPtrBin + 1'b1;
  end

  assign rdData = mem[rdPtrBin[AW-1:0]];
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import cdc_bridge_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          startAcq,
  input  logic          capValid,
  input  logic          dmaAckN,
  input  logic [PW-1:0] wrPtrBin,
  input  logic [PW-1:0] rdPtrBin,
  output logic          wrReady,
  output logic          dmaReqN,
  output logic          underflow,
  output fifoStrobe_t   strobe
);
  logic [PW-1:0] wrGrayNow, rdGrayNow;
  logic [PW-1:0] wrGrayQ, rdGrayQ;
  logic [PW-1:0] wrGraySync, rdGraySync;
  logic          fullFlag, emptyFlag;
  logic          ackDlyN, ackFall;

  assign wrGrayNow = wrPtrBin ^ (wrPtrBin >> 1);
  assign rdGrayNow = rdPtrBin ^ (rdPtrBin >> 1);

  // Registered Gray copies so only glitch-free values cross.
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) wrGrayQ <= '0;
    else       wrGrayQ <= wrGrayNow;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) rdGrayQ <= '0;
    else       rdGrayQ <= rdGrayNow;
  end

  ptr_sync #(.W(PW)) u_wrToRd (
    .clk (rdClk), .rstN(rstN), .din(wrGrayQ), .dout(wrGraySync)
  );

  ptr_sync #(.W(PW)) u_rdToWr (
    .clk (wrClk), .rstN(rstN), .din(rdGrayQ), .dout(rdGraySync)
  );

  // Full: same address, opposite wrap -> top two Gray bits inverted.
  assign fullFlag  = (wrGrayNow == {~rdGraySync[PW-1:PW-2], rdGraySync[PW-3:0]});
  assign emptyFlag = (rdGrayNow == wrGraySync);

  assign wrReady = startAcq & ~fullFlag;
  assign dmaReqN = emptyFlag;

  // Acknowledge falling-edge detect in the read domain.
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) ackDlyN <= 1'b1;
    else       ackDlyN <= dmaAckN;
  end
  assign ackFall = ackDlyN & ~dmaAckN;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)                      underflow <= 1'b0;
    else if (ackFall && emptyFlag)  underflow <= 1'b1;
  end

  always_comb begin
    strobe.push = capValid & wrReady;
    strobe.pop  = ackFall & ~emptyFlag;
  end
endmodule

// File: rtl/capture_dma_fifo.sv
module capture_dma_fifo
  import cdc_bridge_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          startAcq,
  input  logic          capValid,
  input  logic [DW-1:0] capData,
  output logic          wrReady,
  output logic [DW-1:0] rdData,
  output logic          dmaReqN,
  input  logic          dmaAckN,
  output logic          underflow
);
  fifoStrobe_t   strobe;
  logic [PW-1:0] wrPtrBin, rdPtrBin;

  fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .rstN     (rstN),
    .startAcq (startAcq),
    .capValid (capValid),
    .dmaAckN  (dmaAckN),
    .wrPtrBin (wrPtrBin),
    .rdPtrBin (rdPtrBin),
    .wrReady  (wrReady),
    .dmaReqN  (dmaReqN),
    .underflow(underflow),
    .strobe   (strobe)
  );

  fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .wrClk   (wrClk),
    .rdClk   (rdClk),
    .rstN    (rstN),
    .strobe  (strobe),
    .capData (capData),
    .rdData  (rdData),
    .wrPtrBin(wrPtrBin),
    .rdPtrBin(rdPtrBin)
  );
endmodule

// File: rtl/capture_dma_fifo_chk.sv
module capture_dma_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int PW    = 5
) (
  input logic          wrClk,
  input logic          rdClk,
  input logic          rstN,
  input logic          dmaAckN,
  input logic          dmaReqN,
  input logic          underflow,
  input logic [PW-1:0] wrBin,
  input logic [PW-1:0] rdBin
);
  // R3
  no_overflow_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (PW'(wrBin - rdBin) <= PW'(DEPTH)));

  // R4
  req_idle_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdBin == wrBin) |-> dmaReqN);

  // R7
  sticky_underflow_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    underflow |=> underflow);

  // R6
  single_pop_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    !$stable(rdBin) |-> ((rdBin == $past(rdBin) + 1'b1) && !$past(dmaAckN)
                         && $past(dmaAckN, 2)));
endmodule

bind capture_dma_fifo capture_dma_fifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .wrClk    (wrClk),
  .rdClk    (rdClk),
  .rstN     (rstN),
  .dmaAckN  (dmaAckN),
  .dmaReqN  (dmaReqN),
  .underflow(underflow),
  .wrBin    (wrPtrBin),
  .rdBin    (rdPtrBin)
);

// File: tb/test_capture_dma_fifo.sv
module test_capture_dma_fifo;
  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;
  localparam int DEPTH = 16;
  localparam int NVEC = 8;
  // {written byte, expected read byte}
  localparam logic [15:0] VECS [NVEC] = '{
    16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A,
    16'h0101, 16'h8080, 16'h3C3C, 16'hC3C3
  };

  logic wrClk = 0, rdClk = 0, rstN = 0;
  logic startAcq = 0, capValid = 0, dmaAckN = 1;
  logic [7:0] capData = 0;
  logic wrReady, dmaReqN, underflow;
  logic [7:0] rdData;
  int checks = 0, failures = 0;

  always #(WR_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2) rdClk = ~rdClk;

  capture_dma_fifo #(.DEPTH(DEPTH), .DW(8)) i_capture_dma_fifo (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .startAcq(startAcq),
    .capValid(capValid), .capData(capData), .wrReady(wrReady),
    .rdData(rdData), .dmaReqN(dmaReqN), .dmaAckN(dmaAckN),
    .underflow(underflow)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pushByte(input logic [7:0] d);
    @(negedge wrClk);
    capValid = 1; capData = d;
    @(negedge wrClk);
    capValid = 0;
  endtask

  task automatic ackPulse(input int len);
    @(negedge rdClk);
    dmaAckN = 0;
    repeat (len) @(negedge rdClk);
    dmaAckN = 1;
    @(negedge rdClk);
  endtask

  task automatic waitReq();
    for (int i = 0; i < 12 && dmaReqN; i++) @(negedge rdClk);
  endtask

  initial begin
    repeat (50000) @(posedge wrClk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge wrClk);
    rstN = 1;
    repeat (2) @(negedge rdClk);
    // Reset state
    check(dmaReqN == 1, "R8 dmaReqN after reset", dmaReqN, 1);
    check(underflow == 0, "R8 underflow after reset", underflow, 0);
    check(wrReady == 0, "R8 wrReady with startAcq=0", wrReady, 0);
    startAcq = 1; #1;
    check(wrReady == 1, "R1 wrReady with startAcq=1", wrReady, 1);

    // Vector table: write all, then read and compare
    for (int i = 0; i < NVEC; i++) pushByte(VECS[i][15:8]);
    repeat (4) @(negedge rdClk);
    for (int i = 0; i < NVEC; i++) begin
      check(dmaReqN == 0, "R4 request held while data", dmaReqN, 0);
      check(rdData == VECS[i][7:0], "R5 head byte order", rdData, VECS[i][7:0]);
      ackPulse(1);
    end
    check(dmaReqN == 1, "R4 request released when drained", dmaReqN, 1);

    // Writes gated off by startAcq
    startAcq = 0; #1;
    check(wrReady == 0, "R1 wrReady drops with startAcq", wrReady, 0);
    pushByte(8'hAA);
    repeat (8) @(negedge rdClk);
    check(dmaReqN == 1, "R2 byte dropped without startAcq", dmaReqN, 1);

    // Long acknowledge retires one byte
    startAcq = 1;
    pushByte(8'h11);
    pushByte(8'h22);
    waitReq();
    repeat (4) @(negedge rdClk);
    check(rdData == 8'h11, "R5 first byte", rdData, 8'h11);
    ackPulse(5);
    check(rdData == 8'h22, "R6 long ack pops one", rdData, 8'h22);
    check(dmaReqN == 0, "R6 one byte remains", dmaReqN, 0);
    ackPulse(1);
    check(dmaReqN == 1, "R6 empty after second ack", dmaReqN, 1);

    // Fill beyond depth
    repeat (6) @(negedge wrClk);
    for (int i = 0; i < DEPTH + 3; i++) pushByte(8'h40 + 8'(i));
    check(wrReady == 0, "R1 wrReady low when full", wrReady, 0);
    for (int i = 0; i < DEPTH; i++) begin
      waitReq();
      check(rdData == 8'h40 + 8'(i), "R3 kept bytes in order", rdData, 8'h40 + 8'(i));
      ackPulse(1);
    end
    check(dmaReqN == 1, "R3 extra bytes dropped", dmaReqN, 1);
    repeat (6) @(negedge wrClk);
    check(wrReady == 1, "R1 wrReady back after drain", wrReady, 1);

    // Acknowledge while empty
    check(underflow == 0, "R7 no underflow yet", underflow, 0);
    ackPulse(1);
    check(underflow == 1, "R7 underflow set", underflow, 1);
    check(dmaReqN == 1, "R7 still empty", dmaReqN, 1);
    pushByte(8'h5A);
    waitReq();
    check(rdData == 8'h5A, "R7 pointers intact", rdData, 8'h5A);
    ackPulse(1);
    check(dmaReqN == 1, "R7 drained after underflow", dmaReqN, 1);
    check(underflow == 1, "R7 underflow sticky", underflow, 1);

    // Reset clears sticky flag
    rstN = 0;
    repeat (2) @(negedge rdClk);
    check(underflow == 0, "R8 underflow cleared by reset", underflow, 0);
    check(dmaReqN == 1, "R8 empty in reset", dmaReqN, 1);
    rstN = 1;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule